// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block steps an I2C master through one transfer, one byte at a time. It sits between a 16-byte data FIFO and a bit-level bus engine. The engine carries out single bus operations (START, write a byte, read a byte, STOP) through a request/done handshake. The sequencer decides what the engine does next:

- send the address byte or bytes;
- move payload bytes between the engine and the FIFO;
- pick ACK or NACK for each byte it reads;
- stall the bus;
- finish with STOP, or keep the bus for a repeated START.

The host sets up the transfer before starting it. It sets the direction, the address width and the hold flag, loads a down-counting transfer size, and fills the FIFO when transmitting. Writing the target address starts the transfer. The host may rewrite the transfer size while a transfer runs, which extends a long receive past 255 bytes. With hold set, the sequencer stalls on a drained transmit FIFO or a full receive FIFO, and it never issues STOP by itself. Three one-cycle event outputs report completion, receive occupancy reaching 14, and a target NACK.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the bus is idle, no engine request is raised, the transfer size reads zero, receive data is not valid and no event is raised.
- R2: An address write while idle or held issues START and then the address. In 7-bit mode (`cfg_short`=1) the address is one byte `{addr[6:0], dir}`. In 10-bit mode it is `{5'b11110, addr[9:8], dir}` followed by `addr[7:0]`. The dir bit is `cfg_rx`: 0 transmit, 1 receive.
- R3: In transmit mode, payload bytes go out in FIFO order and the transfer size drops by one per completed byte. It never rises except by a host load. With hold clear, STOP follows when the size reaches zero, and `ev_done` pulses when that STOP completes.
- R4: In receive mode, each byte is read with ACK (`eng_ack`=1), except the byte that brings the size to zero, which gets NACK. Received bytes appear at `rx_data` in order, and `rx_valid` is high while the FIFO holds any.
- R5: `ev_thresh` pulses once when receive occupancy rises to 14. It is never raised in transmit mode.
- R6: With hold set in receive mode, a full FIFO stops new reads until the host removes a byte.
- R7: A transfer-size load takes effect on the next cycle, including during a transfer. Raising it during a receive extends the receive by that many bytes.
- R8: In transmit mode with hold set, a drained FIFO with bytes still owed pulses `ev_done` and keeps the bus active with no request. Pushing data resumes the transfer.
- R9: With hold set, reaching size zero pulses `ev_done` and keeps the bus without STOP. An address write then issues a repeated START, and clearing hold issues STOP.
- R10: A target NACK on an address or payload write pulses `ev_nack` and ends the byte stream. The sequencer then issues STOP if hold is clear. If hold is set it keeps the bus with no STOP and no `ev_done`.
- R11: A `fifo_clr` pulse empties the FIFO and zeroes the transfer size by the next cycle, and takes priority over a size load in the same cycle.
- R12: Only one engine operation is outstanding at a time, and a request holds its code and data stable until `eng_done`. Operation codes: 0 START, 1 write, 2 read, 3 STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx | input | 1 | Direction: 1 receive, 0 transmit |
| cfg_short | input | 1 | 1 selects 7-bit addressing, 0 selects 10-bit |
| cfg_hold | input | 1 | Keep the bus: stall on FIFO limits, no automatic STOP |
| fifo_clr | input | 1 | One-cycle pulse: empty FIFO, zero transfer size |
| size_wr | input | 1 | Load the transfer size |
| size_wdata | input | 8 | Transfer size value |
| addr_wr | input | 1 | Address write; starts a transfer when idle or held |
| addr_wdata | input | 10 | Target address |
| tx_push | input | 1 | Push a transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_pop | input | 1 | Remove the head receive byte |
| rx_data | output | 8 | Head receive byte |
| rx_valid | output | 1 | Receive data present |
| bus_active | output | 1 | Transfer in progress or bus held |
| xfer_size | output | 8 | Remaining transfer size |
| eng_req | output | 1 | Operation request to the bit engine |
| eng_op | output | 2 | Operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_ack | output | 1 | For a read: 1 send ACK, 0 send NACK |
| eng_done | input | 1 | Operation finished (one cycle) |
| eng_nack | input | 1 | With done: target did not acknowledge the write |
| eng_rdata | input | 8 | With done: byte read |
| ev_done | output | 1 | Completion event pulse |
| ev_thresh | output | 1 | Receive threshold event pulse |
| ev_nack | output | 1 | Target NACK event pulse |

## Verification
The hardest state to reach from the ports is a stalled receive with a full FIFO followed by a size rewrite. Reaching it needs a receive longer than the FIFO, with hold set and the host not popping. The bench starts a 20-byte receive, lets it freeze after 16 bytes, and confirms that no read is issued. It then raises the remaining size and drains the FIFO back-to-back, so occupancy only falls and the threshold event cannot fire a second time. It finally checks that only the very last of the 22 reads carried NACK and that the bus stays held until hold is cleared.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the I2C byte sequencer: engine operation codes,
// sequencer states and the 10-bit address prefix.
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_W_START,
        S_W_ADR1,
        S_W_ADR2,
        S_STEP,
        S_W_TX,
        S_W_RX,
        S_TX_WAIT,
        S_HELD,
        S_W_STOP
    } seq_state_e;

    localparam int          TARGET_AW   = 10;
    localparam logic [4:0]  WIDE_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_seq_fifo.sv
// Byte FIFO shared by both directions.
// Head is visible without a pop (show-ahead). Push on full and pop on empty
// are dropped. Clear has priority over push and pop.
// Assumes DEPTH is a power of two.
module i2c_seq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      level,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i2c_seq_count.sv
// Down-counting transfer size. Priority: clear, then host load, then
// decrement. Decrement saturates at zero.
module i2c_seq_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero,
    output logic         one
);
    assign zero = (cnt == '0);
    assign one  = (cnt == W'(1));

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (dec && !zero)  cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/i2c_seq_fsm.sv
// Transfer state machine.
// Issues one engine operation at a time and keeps the request registered and
// stable until done. Chooses each next byte from the size count, the FIFO
// state, the direction and the hold flag.
// Assumes the host keeps cfg_rx and cfg_short steady during a transfer.
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_rx,
    input  logic                 cfg_short,
    input  logic                 cfg_hold,
    input  logic                 addr_wr,
    input  logic [TARGET_AW-1:0] addr_wdata,
    input  logic                 cnt_zero,
    input  logic                 cnt_one,
    input  logic                 fifo_empty,
    input  logic                 fifo_full,
    input  logic [DW-1:0]        fifo_head,
    input  logic                 eng_done,
    input  logic                 eng_nack,
    output logic                 eng_req,
    output bus_op_e              eng_op,
    output logic [DW-1:0]        eng_wdata,
    output logic                 eng_ack,
    output logic                 tx_pop,
    output logic                 rx_push,
    output logic                 cnt_dec,
    output logic                 ev_done,
    output logic                 ev_nack,
    output logic                 bus_active
);
    seq_state_e           state;
    logic [TARGET_AW-1:0] addr_q;

    // Handshake side effects of the current state.
    always_comb begin
        tx_pop     = (state == S_STEP) && !cnt_zero && !cfg_rx && !fifo_empty;
        rx_push    = (state == S_W_RX) && eng_done && !fifo_full;
        cnt_dec    = eng_done && ((state == S_W_TX) || (state == S_W_RX));
        bus_active = (state != S_IDLE);
    end

    // State, engine request and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            addr_q    <= '0;
            eng_req   <= 1'b0;
            eng_op    <= OP_START;
            eng_wdata <= '0;
            eng_ack   <= 1'b0;
            ev_done   <= 1'b0;
            ev_nack   <= 1'b0;
        end else begin
            ev_done <= 1'b0;
            ev_nack <= 1'b0;
            case (state)
                S_IDLE, S_HELD: begin
                    if (addr_wr) begin
                        addr_q  <= addr_wdata;
                        eng_req <= 1'b1;
                        eng_op  <= OP_START;
                        state   <= S_W_START;
                    end else if (state == S_HELD && !cfg_hold) begin
                        eng_req <= 1'b1;
                        eng_op  <= OP_STOP;
                        state   <= S_W_STOP;
                    end
                end
                S_W_START: if (eng_done) begin
                    eng_op    <= OP_WRITE;
                    eng_wdata <= cfg_short ? {addr_q[6:0], cfg_rx}
                                           : {WIDE_PREFIX, addr_q[9:8], cfg_rx};
                    state     <= S_W_ADR1;
                end
                S_W_ADR1, S_W_ADR2, S_W_TX: if (eng_done) begin
                    if (eng_nack) begin
                        ev_nack <= 1'b1;
                        if (cfg_hold) begin
                            eng_req <= 1'b0;
                            state   <= S_HELD;
                        end else begin
                            eng_op <= OP_STOP;
                            state  <= S_W_STOP;
                        end
                    end else if (state == S_W_ADR1 && !cfg_short) begin
                        eng_wdata <= addr_q[7:0];
                        state     <= S_W_ADR2;
                    end else begin
                        eng_req <= 1'b0;
                        state   <= S_STEP;
                    end
                end
                S_STEP: begin
                    if (cnt_zero) begin
                        if (cfg_hold) begin
                            ev_done <= 1'b1;
                            state   <= S_HELD;
                        end else begin
                            eng_req <= 1'b1;
                            eng_op  <= OP_STOP;
                            state   <= S_W_STOP;
                        end
                    end else if (!cfg_rx) begin
                        if (!fifo_empty) begin
                            eng_req   <= 1'b1;
                            eng_op    <= OP_WRITE;
                            eng_wdata <= fifo_head;
                            state     <= S_W_TX;
                        end else if (cfg_hold) begin
                            ev_done <= 1'b1;
                            state   <= S_TX_WAIT;
                        end else begin
                            eng_req <= 1'b1;
                            eng_op  <= OP_STOP;
                            state   <= S_W_STOP;
                        end
                    end else if (!(fifo_full && cfg_hold)) begin
                        eng_req <= 1'b1;
                        eng_op  <= OP_READ;
                        eng_ack <= !cnt_one;
                        state   <= S_W_RX;
                    end
                end
                S_W_RX: if (eng_done) begin
                    eng_req <= 1'b0;
                    state   <= S_STEP;
                end
                S_TX_WAIT: begin
                    if (!fifo_empty) begin
                        state <= S_STEP;
                    end else if (!cfg_hold) begin
                        eng_req <= 1'b1;
                        eng_op  <= OP_STOP;
                        state   <= S_W_STOP;
                    end
                end
                S_W_STOP: if (eng_done) begin
                    eng_req <= 1'b0;
                    ev_done <= 1'b1;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_xfer_seq.sv
// Top of the I2C byte sequencer.
// Routes the shared FIFO by direction: the host fills it when transmitting
// and the engine fills it when receiving. Also derives the receive
// threshold event from the FIFO level.
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W     = 8,
    parameter int SIZE_W     = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int THRESH    = FIFO_DEPTH - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_rx,
    input  logic                 cfg_short,
    input  logic                 cfg_hold,
    input  logic                 fifo_clr,
    input  logic                 size_wr,
    input  logic [SIZE_W-1:0]    size_wdata,
    input  logic                 addr_wr,
    input  logic [9:0]           addr_wdata,
    input  logic                 tx_push,
    input  logic [DATA_W-1:0]    tx_data,
    input  logic                 rx_pop,
    output logic [DATA_W-1:0]    rx_data,
    output logic                 rx_valid,
    output logic                 bus_active,
    output logic [SIZE_W-1:0]    xfer_size,
    output logic                 eng_req,
    output logic [1:0]           eng_op,
    output logic [DATA_W-1:0]    eng_wdata,
    output logic                 eng_ack,
    input  logic                 eng_done,
    input  logic                 eng_nack,
    input  logic [DATA_W-1:0]    eng_rdata,
    output logic                 ev_done,
    output logic                 ev_thresh,
    output logic                 ev_nack
);
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [DATA_W-1:0] fifo_din, fifo_head;
    logic [LVL_W-1:0]  fifo_level, level_d1;
    logic              tx_pop, rx_push, cnt_dec, cnt_zero, cnt_one;
    bus_op_e           op_e;

    assign fifo_push = cfg_rx ? rx_push : (tx_push && !fifo_full);
    assign fifo_din  = cfg_rx ? eng_rdata : tx_data;
    assign fifo_pop  = cfg_rx ? (rx_pop && !fifo_empty) : tx_pop;
    assign rx_data   = fifo_head;
    assign rx_valid  = cfg_rx && !fifo_empty;
    assign eng_op    = op_e;
    assign ev_thresh = cfg_rx && (fifo_level == LVL_W'(THRESH))
                              && (level_d1 < LVL_W'(THRESH));

    // Previous FIFO level, used to detect the rise to the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d1 <= '0;
        else        level_d1 <= fifo_level;
    end

    i2c_seq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .level (fifo_level),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    i2c_seq_count #(.W(SIZE_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .load     (size_wr),
        .load_val (size_wdata),
        .dec      (cnt_dec),
        .cnt      (xfer_size),
        .zero     (cnt_zero),
        .one      (cnt_one)
    );

    i2c_seq_fsm #(.DW(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_rx     (cfg_rx),
        .cfg_short  (cfg_short),
        .cfg_hold   (cfg_hold),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .fifo_head  (fifo_head),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .eng_req    (eng_req),
        .eng_op     (op_e),
        .eng_wdata  (eng_wdata),
        .eng_ack    (eng_ack),
        .tx_pop     (tx_pop),
        .rx_push    (rx_push),
        .cnt_dec    (cnt_dec),
        .ev_done    (ev_done),
        .ev_nack    (ev_nack),
        .bus_active (bus_active)
    );

endmodule

// File: rtl/i2c_xfer_seq_chk.sv
// Property checker for the I2C byte sequencer, bound to the top module.
// Relates the handshake, the size counter and the FIFO state over time.
module i2c_xfer_seq_chk
    import i2c_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_rx,
    input logic       cfg_hold,
    input logic       fifo_clr,
    input logic       size_wr,
    input logic [7:0] size_wdata,
    input logic       eng_req,
    input logic [1:0] eng_op,
    input logic [7:0] eng_wdata,
    input logic       eng_done,
    input logic       eng_nack,
    input logic       bus_active,
    input logic [7:0] xfer_size,
    input logic       rx_valid,
    input logic       ev_thresh,
    input logic       ev_nack,
    input logic       fifo_full
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> !eng_req);

    p_size_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !size_wr |=> (xfer_size <= $past(xfer_size)));

    p_thresh_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_thresh |-> cfg_rx);

    p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rx && cfg_hold && fifo_full && !eng_req)
        |=> !(eng_req && eng_op == 2'(OP_READ)));

    p_size_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && !fifo_clr) |=> (xfer_size == $past(size_wdata)));

    p_nack_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_nack && eng_op == 2'(OP_WRITE)) |=> ev_nack);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (xfer_size == 8'd0 && !fifo_full && !rx_valid));

    p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done)
        |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rx     (cfg_rx),
    .cfg_hold   (cfg_hold),
    .fifo_clr   (fifo_clr),
    .size_wr    (size_wr),
    .size_wdata (size_wdata),
    .eng_req    (eng_req),
    .eng_op     (eng_op),
    .eng_wdata  (eng_wdata),
    .eng_done   (eng_done),
    .eng_nack   (eng_nack),
    .bus_active (bus_active),
    .xfer_size  (xfer_size),
    .rx_valid   (rx_valid),
    .ev_thresh  (ev_thresh),
    .ev_nack    (ev_nack),
    .fifo_full  (fifo_full)
);

// File: tb/i2c_xfer_seq_tb.sv
// Self-checking bench for the I2C byte sequencer.
// A behavioural bit engine logs every operation. Expected operation lists
// are built from the requirements.
module i2c_xfer_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_rx, cfg_short, cfg_hold, fifo_clr, size_wr, addr_wr;
    logic [7:0] size_wdata, tx_data, eng_rdata, rx_data, eng_wdata;
    logic [9:0] addr_wdata;
    logic       tx_push, rx_pop, rx_valid, bus_active, eng_req, eng_ack;
    logic       eng_done, eng_nack, ev_done, ev_thresh, ev_nack;
    logic [7:0] xfer_size;
    logic [1:0] eng_op;

    always #10 clk = ~clk;

    i2c_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_short(cfg_short),
        .cfg_hold(cfg_hold), .fifo_clr(fifo_clr), .size_wr(size_wr),
        .size_wdata(size_wdata), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .bus_active(bus_active),
        .xfer_size(xfer_size), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_rdata(eng_rdata), .ev_done(ev_done),
        .ev_thresh(ev_thresh), .ev_nack(ev_nack)
    );

    // Stimulus/result table: direction, addressing, size, address, op count.
    localparam int         NROWS        = 4;
    localparam bit         T_RX   [4]   = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam bit         T_SHORT[4]   = '{1'b1, 1'b1, 1'b0, 1'b0};
    localparam int         T_SIZE [4]   = '{3, 2, 1, 1};
    localparam logic [9:0] T_ADDR [4]   = '{10'h05A, 10'h021, 10'h2C7, 10'h155};
    localparam int         T_NOPS [4]   = '{6, 5, 5, 5};

    int checks = 0, errors = 0;
    int done_cnt = 0, nack_cnt = 0, thr_cnt = 0;
    int op_n = 0, nack_at = -1, rd_seq = 0;
    logic [1:0] op_log  [64];
    logic [7:0] dat_log [64];
    logic       ack_log [64];
    logic [1:0] e_op  [16];
    logic [7:0] e_dat [16];
    logic       e_ack [16];
    int d0, n0, t0, n;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Behavioural bit engine: two-cycle latency, logs each operation.
    initial begin
        eng_done = 1'b0; eng_nack = 1'b0; eng_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (eng_req) begin
                if (op_n < 64) begin
                    op_log[op_n]  = eng_op;
                    dat_log[op_n] = eng_wdata;
                    ack_log[op_n] = eng_ack;
                end
                repeat (2) @(negedge clk);
                eng_done  = 1'b1;
                eng_nack  = (op_n == nack_at);
                eng_rdata = 8'h40 + 8'(rd_seq);
                if (eng_op == 2'd2) rd_seq++;
                op_n++;
                @(negedge clk);
                eng_done = 1'b0;
                eng_nack = 1'b0;
            end
        end
    end

    // Event pulse counters.
    initial forever begin
        @(negedge clk);
        if (rst_n === 1'b1) begin
            if (ev_done)   done_cnt++;
            if (ev_nack)   nack_cnt++;
            if (ev_thresh) thr_cnt++;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_clr();
        fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    endtask

    task automatic load_size(logic [7:0] v);
        size_wr = 1'b1; size_wdata = v; @(negedge clk); size_wr = 1'b0;
    endtask

    task automatic push(logic [7:0] b);
        tx_push = 1'b1; tx_data = b; @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic go(logic [9:0] a);
        addr_wr = 1'b1; addr_wdata = a; @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 5000 && bus_active; g++) @(negedge clk);
    endtask

    task automatic wait_done(int target);
        for (int g = 0; g < 5000 && done_cnt < target; g++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; cfg_rx = 1'b0; cfg_short = 1'b1; cfg_hold = 1'b0;
        fifo_clr = 1'b0; size_wr = 1'b0; size_wdata = 8'h00; addr_wr = 1'b0;
        addr_wdata = 10'h000; tx_push = 1'b0; tx_data = 8'h00; rx_pop = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check("R1 bus_active", bus_active, 0);
        check("R1 eng_req", eng_req, 0);
        check("R1 xfer_size", xfer_size, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 ev_done", ev_done, 0);

        // Table of plain transfers (R2, R3, R4, R12)
        for (int r = 0; r < NROWS; r++) begin
            cfg_rx = T_RX[r]; cfg_short = T_SHORT[r]; cfg_hold = 1'b0;
            pulse_clr();
            load_size(8'(T_SIZE[r]));
            if (!T_RX[r])
                for (int k = 0; k < T_SIZE[r]; k++) push(8'hC0 + 8'(k));
            op_n = 0; rd_seq = 0; nack_at = -1; d0 = done_cnt;
            go(T_ADDR[r]);
            wait_idle();
            check("R12 op count", op_n, T_NOPS[r]);
            check("R3 done pulse", done_cnt, d0 + 1);
            n = 0;
            e_op[n] = 2'd0; n++;
            if (T_SHORT[r]) begin
                e_op[n] = 2'd1; e_dat[n] = {T_ADDR[r][6:0], T_RX[r]}; n++;
            end else begin
                e_op[n] = 2'd1; e_dat[n] = {5'b11110, T_ADDR[r][9:8], T_RX[r]}; n++;
                e_op[n] = 2'd1; e_dat[n] = T_ADDR[r][7:0]; n++;
            end
            for (int k = 0; k < T_SIZE[r]; k++) begin
                if (T_RX[r]) begin
                    e_op[n] = 2'd2; e_ack[n] = (k != T_SIZE[r] - 1);
                end else begin
                    e_op[n] = 2'd1; e_dat[n] = 8'hC0 + 8'(k);
                end
                n++;
            end
            e_op[n] = 2'd3; n++;
            for (int i = 0; i < n && i < 16; i++) begin
                check("R2 op code", op_log[i], e_op[i]);
                if (e_op[i] == 2'd1) check("R2 R3 write byte", dat_log[i], e_dat[i]);
                if (e_op[i] == 2'd2) check("R4 ack choice", ack_log[i], e_ack[i]);
            end
            if (T_RX[r]) begin
                for (int k = 0; k < T_SIZE[r]; k++) begin
                    check("R4 rx_valid", rx_valid, 1);
                    check("R4 rx data", rx_data, 8'h40 + 8'(k));
                    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
                end
                check("R4 rx_valid empty", rx_valid, 0);
            end
        end

        // Long receive: threshold, full stall, size extension, held end
        cfg_rx = 1'b1; cfg_short = 1'b1; cfg_hold = 1'b1;
        pulse_clr();
        load_size(8'd20);
        op_n = 0; rd_seq = 0; nack_at = -1; t0 = thr_cnt; d0 = done_cnt;
        go(10'h010);
        for (int g = 0; g < 2000 && op_n < 18; g++) @(negedge clk);
        tick(30);
        check("R6 no read while full", op_n, 18);
        check("R6 request idle", eng_req, 0);
        check("R5 threshold once", thr_cnt, t0 + 1);
        check("R3 size after 16 bytes", xfer_size, 4);
        load_size(8'd6);
        check("R7 size reload", xfer_size, 6);
        rx_pop = 1'b1;
        for (int k = 0; k < 16; k++) begin
            check("R4 rx data long", rx_data, 8'h40 + 8'(k));
            @(negedge clk);
        end
        rx_pop = 1'b0;
        wait_done(d0 + 1);
        tick(2);
        check("R9 held after count", bus_active, 1);
        for (int k = 0; k < 6; k++) begin
            check("R7 extended data", rx_data, 8'h50 + 8'(k));
            rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        end
        check("R7 total reads", op_n, 24);
        check("R4 last read nack", ack_log[23], 0);
        check("R4 prior read ack", ack_log[22], 1);
        check("R9 no stop while held", op_log[23], 2);
        check("R5 no second threshold", thr_cnt, t0 + 1);
        cfg_hold = 1'b0;
        tick(1);
        wait_idle();
        check("R9 stop on hold clear", op_log[24], 3);
        check("R9 done on stop", done_cnt, d0 + 2);

        // Transmit drain with hold, resume, repeated start
        cfg_rx = 1'b0; cfg_short = 1'b1; cfg_hold = 1'b1;
        pulse_clr();
        load_size(8'd4);
        push(8'h11); push(8'h22);
        op_n = 0; d0 = done_cnt;
        go(10'h030);
        wait_done(d0 + 1);
        tick(20);
        check("R8 stalled op count", op_n, 4);
        check("R8 bus kept", bus_active, 1);
        check("R8 no request", eng_req, 0);
        push(8'h33); push(8'h44);
        wait_done(d0 + 2);
        tick(2);
        check("R8 resumed ops", op_n, 6);
        check("R8 resumed byte a", dat_log[4], 8'h33);
        check("R8 resumed byte b", dat_log[5], 8'h44);
        check("R9 held at zero", bus_active, 1);
        cfg_hold = 1'b0; addr_wr = 1'b1; addr_wdata = 10'h030;
        @(negedge clk); addr_wr = 1'b0;
        wait_idle();
        check("R9 repeated start", op_log[6], 0);
        check("R9 op count", op_n, 9);
        check("R9 final stop", op_log[8], 3);
        check("R9 done after stop", done_cnt, d0 + 3);

        // NACK on payload byte, hold clear
        cfg_hold = 1'b0;
        pulse_clr();
        load_size(8'd3);
        push(8'hAA); push(8'hBB); push(8'hCC);
        op_n = 0; nack_at = 2; n0 = nack_cnt; d0 = done_cnt;
        go(10'h050);
        wait_idle();
        check("R10 nack event", nack_cnt, n0 + 1);
        check("R10 ops after nack", op_n, 4);
        check("R10 stop after nack", op_log[3], 3);

        // NACK on address, hold set
        cfg_hold = 1'b1;
        pulse_clr();
        load_size(8'd1);
        push(8'h05);
        op_n = 0; nack_at = 1; d0 = done_cnt;
        go(10'h050);
        for (int g = 0; g < 2000 && nack_cnt < n0 + 2; g++) @(negedge clk);
        tick(10);
        check("R10 address nack event", nack_cnt, n0 + 2);
        check("R10 no stop when held", op_n, 2);
        check("R10 bus kept", bus_active, 1);
        check("R10 no done", done_cnt, d0);
        nack_at = -1;
        cfg_hold = 1'b0;
        tick(1);
        wait_idle();
        check("R9 stop on release", op_log[2], 3);

        // FIFO clear
        cfg_rx = 1'b0; cfg_hold = 1'b0;
        load_size(8'd5);
        push(8'h01); push(8'h02); push(8'h03);
        fifo_clr = 1'b1; size_wr = 1'b1; size_wdata = 8'd9;
        @(negedge clk);
        fifo_clr = 1'b0; size_wr = 1'b0;
        check("R11 size cleared", xfer_size, 0);
        op_n = 0;
        go(10'h050);
        wait_idle();
        check("R11 no data sent", op_n, 3);
        check("R11 stop follows address", op_log[2], 3);

        finish_run();
    end

endmodule